// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Generator

This block drives the four switches of a full-bridge inverter built from two half-bridge legs. One leg leads and the other lags. Each leg runs at a fixed half-period duty ratio, with its high-side and low-side gates complementary apart from a per-leg deadtime. The lagging leg's high-side rise is delayed from the leading leg's high-side rise by a programmable shift. That shift sets the width of the positive and negative pulses of the three-level bridge voltage.

Delivered power is steered in two ways. A longer switching period (lower frequency) reduces power. A smaller pulse-width fraction, programmed in hundredths of a half period, gives narrower pulses. A slow burst input switches the whole bridge off and back on. All settings pass through clamps. New settings take effect only at a period boundary or while the bridge is stopped, so every period the bridge produces is well formed.

Top module: `pfb_bridge_gate`

## Requirements
- R1: After reset, and one clock after either `en` or `burst_on` is low at a rising edge, all four gate outputs are 0.
- R2: With period P and half period H = floor(P/2), the leading leg position is the period count c (0 to P-1). The leading high gate is 1 exactly for c in [dA, H). The leading low gate is 1 exactly for c in [H+dA, P).
- R3: The lagging leg uses position p = (c - S) mod P, where S = floor(H*w/100) and w is the pulse-width word. Its high gate is 1 exactly for p in [dB, H), and its low gate is 1 exactly for p in [H+dB, P).
- R4: The high and low gates of one leg are never 1 in the same cycle. Both are 0 during that leg's deadtime.
- R5: The pulse-width word is clamped to the range 35 to 99 before use.
- R6: Each deadtime word is clamped to at least DT_MIN (default 1) and at most H-1.
- R7: The period word is clamped to at least PER_MIN (default 8).
- R8: Period, pulse-width and deadtime inputs are taken only in the last count of a period (c = P-1) or while the bridge is stopped. Changes at any other time have no effect until then.
- R9: When the bridge starts, its first gate pattern is the one for count c = 0, with the settings present on the cycle before start.
- R10: `burst_on` low stops the bridge exactly as `en` low does, and raising it restarts at count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Bridge enable |
| burst_on | input | 1 | Slow burst gate; high lets the bridge switch |
| period_i | input | CW (12) | Switching period in clock counts |
| width_pct_i | input | PW (7) | Pulse-width fraction in hundredths |
| dead_lead_i | input | CW (12) | Leading-leg deadtime in counts |
| dead_lag_i | input | CW (12) | Lagging-leg deadtime in counts |
| lead_hi_o | output | 1 | Leading-leg high-side gate |
| lead_lo_o | output | 1 | Leading-leg low-side gate |
| lag_hi_o | output | 1 | Lagging-leg high-side gate |
| lag_lo_o | output | 1 | Lagging-leg low-side gate |

## Verification
Each gate output is registered once from the period count. The pattern for count c therefore appears one clock after the edge at which the counter holds c, and a stop takes effect one clock after the edge that samples it. The bench drives inputs on the falling edge and pushes one expected gate vector for each coming rising edge. A monitor pops and compares that vector shortly after the edge. Every expectation is thus aligned to the exact cycle, including the delayed adoption of settings changed in the middle of a period.

// File: rtl/pfb_pkg.sv
// Shared definitions for the phase-shifted bridge gate generator.
// Assumes: nothing beyond the types declared here.
package pfb_pkg;
    // Gate pair of one half-bridge leg.
    typedef struct packed {
        logic hi;
        logic lo;
    } leg_gate_t;

    // Leg indices; the leading leg has no shift.
    localparam int LEG_LEAD = 0;
    localparam int LEG_LAG  = 1;
    localparam int NUM_LEGS = 2;

    // Pulse-width fraction limits in hundredths.
    localparam int PCT_LO = 35;
    localparam int PCT_HI = 99;
endpackage

// File: rtl/pfb_cfg.sv
// Clamps the incoming settings and holds the active copy used by the
// counter and the legs. A new copy is taken only when load is high.
// Assumes: DT_MIN <= PER_MIN/2 - 1, so the deadtime clamp range is never empty.
module pfb_cfg #(
    parameter int CW      = 12,
    parameter int PW      = 7,
    parameter int PER_MIN = 8,
    parameter int DT_MIN  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] per_i,
    input  logic [PW-1:0] pct_i,
    input  logic [CW-1:0] dta_i,
    input  logic [CW-1:0] dtb_i,
    output logic [CW-1:0] per_o,
    output logic [CW-1:0] half_o,
    output logic [CW-1:0] shift_o,
    output logic [CW-1:0] dta_o,
    output logic [CW-1:0] dtb_o
);
    import pfb_pkg::*;

    localparam int PRW = CW + PW;

    logic [CW-1:0]  per_c, half_c, shift_c, dta_c, dtb_c;
    logic [PW-1:0]  pct_c;
    logic [PRW-1:0] prod;

    // Bound a deadtime to [DT_MIN, h-1].
    function automatic logic [CW-1:0] clamp_dt(input logic [CW-1:0] d,
                                               input logic [CW-1:0] h);
        logic [CW-1:0] r;
        r = d;
        if (r < CW'(DT_MIN)) r = CW'(DT_MIN);
        if (r > h - CW'(1))  r = h - CW'(1);
        return r;
    endfunction

    // Clamp every setting and derive the half period and leg shift.
    always_comb begin
        per_c   = (per_i < CW'(PER_MIN)) ? CW'(PER_MIN) : per_i;
        half_c  = per_c >> 1;
        pct_c   = pct_i;
        if (pct_c < PW'(PCT_LO)) pct_c = PW'(PCT_LO);
        if (pct_c > PW'(PCT_HI)) pct_c = PW'(PCT_HI);
        prod    = {{PW{1'b0}}, half_c} * {{CW{1'b0}}, pct_c};
        shift_c = CW'(prod / PRW'(100));
        dta_c   = clamp_dt(dta_i, half_c);
        dtb_c   = clamp_dt(dtb_i, half_c);
    end

    // Hold the active settings; refresh only on load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_o   <= CW'(PER_MIN);
            half_o  <= CW'(PER_MIN / 2);
            shift_o <= '0;
            dta_o   <= CW'(DT_MIN);
            dtb_o   <= CW'(DT_MIN);
        end else if (load) begin
            per_o   <= per_c;
            half_o  <= half_c;
            shift_o <= shift_c;
            dta_o   <= dta_c;
            dtb_o   <= dtb_c;
        end
    end

    // R8
    hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> ($stable(per_o) && $stable(shift_o) && $stable(dta_o) && $stable(dtb_o)));
    // R7
    per_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        per_o >= CW'(PER_MIN));
    // R6
    dt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dta_o >= CW'(DT_MIN)) && (dta_o < half_o) && (dtb_o >= CW'(DT_MIN)) && (dtb_o < half_o));
    // R5
    shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        shift_o <= half_o);
endmodule

// File: rtl/pfb_phase_ctr.sv
// Period counter. It runs 0..per-1 while run is high and sits at 0
// while stopped. wrap marks the last count of a running period.
// Assumes: per >= 2 (guaranteed by the settings clamp).
module pfb_phase_ctr #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic [CW-1:0] per,
    output logic [CW-1:0] cnt,
    output logic          wrap
);
    // Flag the final count of the period.
    always_comb wrap = run && (cnt == per - CW'(1));

    // Advance, wrap, or park at zero.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else                cnt <= cnt + CW'(1);
    end

    // R9
    restart_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> cnt == '0);
    // R2
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < per);
endmodule

// File: rtl/pfb_leg_gate.sv
// Gate pair for one half-bridge leg. The leg position is the period
// count delayed by shift. The high side conducts in [dt, half) and the
// low side in [half+dt, per). Outputs are registered and forced low
// while stopped.
// Assumes: shift <= half, 1 <= dt < half, cnt < per.
module pfb_leg_gate #(
    parameter int CW = 12
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [CW-1:0]      cnt,
    input  logic [CW-1:0]      per,
    input  logic [CW-1:0]      half,
    input  logic [CW-1:0]      shift,
    input  logic [CW-1:0]      dt,
    output pfb_pkg::leg_gate_t gate
);
    logic [CW:0] pos, half_x, dt_x;
    logic        hi_n, lo_n;

    // Leg position within the period and the two conduction windows.
    always_comb begin
        half_x = {1'b0, half};
        dt_x   = {1'b0, dt};
        if (cnt >= shift) pos = {1'b0, cnt} - {1'b0, shift};
        else              pos = {1'b0, cnt} + {1'b0, per} - {1'b0, shift};
        hi_n = (pos >= dt_x) && (pos < half_x);
        lo_n = (pos >= half_x + dt_x);
    end

    // Register the gates; all low when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) gate <= '0;
        else                gate <= '{hi: hi_n, lo: lo_n};
    end

    // R4
    no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(gate.hi && gate.lo));
    // R6
    lo_to_hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate.lo) |-> !gate.hi);
    // R6
    hi_to_lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(gate.hi) |-> !gate.lo);
endmodule

// File: rtl/pfb_bridge_gate.sv
// Top of the phase-shifted bridge gate generator: settings holder, period
// counter and one gate generator per leg. The leading leg has zero shift.
// The lagging leg is shifted by the programmed pulse-width fraction of a
// half period.
// Assumes: burst_on and en are synchronous to clk.
module pfb_bridge_gate #(
    parameter int CW      = 12,
    parameter int PW      = 7,
    parameter int PER_MIN = 8,
    parameter int DT_MIN  = 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          burst_on,
    input  logic [CW-1:0] period_i,
    input  logic [PW-1:0] width_pct_i,
    input  logic [CW-1:0] dead_lead_i,
    input  logic [CW-1:0] dead_lag_i,
    output logic          lead_hi_o,
    output logic          lead_lo_o,
    output logic          lag_hi_o,
    output logic          lag_lo_o
);
    import pfb_pkg::*;

    logic          run, wrap;
    logic [CW-1:0] cnt, per_a, half_a, shift_a, dta_a, dtb_a;
    logic [CW-1:0] shift_v [NUM_LEGS];
    logic [CW-1:0] dt_v    [NUM_LEGS];
    leg_gate_t     gate_v  [NUM_LEGS];

    // Bridge switches only when both enable and burst gate are high.
    always_comb run = en && burst_on;

    pfb_cfg #(.CW(CW), .PW(PW), .PER_MIN(PER_MIN), .DT_MIN(DT_MIN)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(!run || wrap),
        .per_i(period_i), .pct_i(width_pct_i),
        .dta_i(dead_lead_i), .dtb_i(dead_lag_i),
        .per_o(per_a), .half_o(half_a), .shift_o(shift_a),
        .dta_o(dta_a), .dtb_o(dtb_a)
    );

    pfb_phase_ctr #(.CW(CW)) u_ctr (
        .clk(clk), .rst_n(rst_n), .run(run), .per(per_a),
        .cnt(cnt), .wrap(wrap)
    );

    // Per-leg shift and deadtime selection.
    always_comb begin
        shift_v[LEG_LEAD] = '0;
        shift_v[LEG_LAG]  = shift_a;
        dt_v[LEG_LEAD]    = dta_a;
        dt_v[LEG_LAG]     = dtb_a;
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        pfb_leg_gate #(.CW(CW)) u_leg (
            .clk(clk), .rst_n(rst_n), .run(run), .cnt(cnt),
            .per(per_a), .half(half_a), .shift(shift_v[g]), .dt(dt_v[g]),
            .gate(gate_v[g])
        );
    end

    // Map leg gates to the output pins.
    always_comb begin
        lead_hi_o = gate_v[LEG_LEAD].hi;
        lead_lo_o = gate_v[LEG_LEAD].lo;
        lag_hi_o  = gate_v[LEG_LAG].hi;
        lag_lo_o  = gate_v[LEG_LAG].lo;
    end

    // R1
    idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && burst_on) |=> !(lead_hi_o || lead_lo_o || lag_hi_o || lag_lo_o));
    // R10
    burst_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !burst_on) |=> !(lead_hi_o || lag_hi_o));
endmodule

// File: tb/pfb_bridge_gate_test.sv
module pfb_bridge_gate_test;
    localparam int CW = 12;
    localparam int PW = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0, burst_on = 1'b0;
    logic [CW-1:0] period_i = 12'd40, dead_lead_i = 12'd3, dead_lag_i = 12'd2;
    logic [PW-1:0] width_pct_i = 7'd60;
    logic lead_hi_o, lead_lo_o, lag_hi_o, lag_lo_o;

    int checks = 0, errors = 0;
    bit done = 0;
    string cur_tag = "R1";

    logic [3:0] exp_q [$];
    string      tag_q [$];

    // bench model state
    int m_cnt = 0, m_p = 8, m_h = 4, m_s = 0, m_da = 1, m_db = 1;

    pfb_bridge_gate uut (
        .clk(clk), .rst_n(rst_n), .en(en), .burst_on(burst_on),
        .period_i(period_i), .width_pct_i(width_pct_i),
        .dead_lead_i(dead_lead_i), .dead_lag_i(dead_lag_i),
        .lead_hi_o(lead_hi_o), .lead_lo_o(lead_lo_o),
        .lag_hi_o(lag_hi_o), .lag_lo_o(lag_lo_o)
    );

    always #10 clk = ~clk;

    // Take settings per R5, R6, R7.
    task automatic take_cfg();
        int w;
        m_p = (int'(period_i) < 8) ? 8 : int'(period_i);
        m_h = m_p / 2;
        w = int'(width_pct_i);
        if (w < 35) w = 35;
        if (w > 99) w = 99;
        m_s = (m_h * w) / 100;
        m_da = int'(dead_lead_i);
        if (m_da < 1) m_da = 1;
        if (m_da > m_h - 1) m_da = m_h - 1;
        m_db = int'(dead_lag_i);
        if (m_db < 1) m_db = 1;
        if (m_db > m_h - 1) m_db = m_h - 1;
    endtask

    // Leg gates per R2/R3 for position p and deadtime d.
    function automatic logic [1:0] leg_exp(int p, int d);
        return {(p >= d && p < m_h), (p >= m_h + d)};
    endfunction

    // Driver: push the expectation for each coming rising edge.
    task automatic step(int n);
        for (int i = 0; i < n; i++) begin
            logic [3:0] e;
            if (!rst_n || !(en && burst_on)) begin
                e = 4'b0000;
                m_cnt = 0;
                take_cfg();
            end else begin
                int pb;
                pb = (m_cnt >= m_s) ? m_cnt - m_s : m_cnt + m_p - m_s;
                e = {leg_exp(m_cnt, m_da), leg_exp(pb, m_db)};
                if (m_cnt == m_p - 1) begin
                    m_cnt = 0;
                    take_cfg();
                end else m_cnt++;
            end
            exp_q.push_back(e);
            tag_q.push_back(cur_tag);
            @(negedge clk);
        end
    endtask

    // Monitor: compare after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [3:0] e, a;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                a = {lead_hi_o, lead_lo_o, lag_hi_o, lag_lo_o};
                checks++;
                if (a !== e) begin
                    errors++;
                    $display("FAIL %s at %0t: gates got %b expected %b", t, $time, a, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        cur_tag = "R1 reset";
        step(4);
        rst_n = 1'b1;
        step(3);
        // R2 R3 R9: start with P=40, w=60
        cur_tag = "R2 R3 R9";
        en = 1'b1; burst_on = 1'b1;
        step(100);
        // R8: change settings in mid period
        cur_tag = "R8";
        period_i = 12'd60; width_pct_i = 7'd99; dead_lag_i = 12'd5;
        step(150);
        // R2 R3 odd period
        cur_tag = "R2 R3 odd";
        period_i = 12'd41; width_pct_i = 7'd50;
        step(100);
        // R5 low and high clamps
        cur_tag = "R5 low";
        width_pct_i = 7'd10;
        step(90);
        cur_tag = "R5 high";
        width_pct_i = 7'd120;
        step(90);
        // R6 deadtime clamps
        cur_tag = "R6";
        width_pct_i = 7'd70; dead_lead_i = 12'd0; dead_lag_i = 12'd100;
        step(100);
        // R7 period floor
        cur_tag = "R7";
        period_i = 12'd3; dead_lead_i = 12'd2; dead_lag_i = 12'd1;
        step(50);
        // R10 burst off then restart
        cur_tag = "R10";
        period_i = 12'd30;
        step(7);
        burst_on = 1'b0;
        step(12);
        burst_on = 1'b1;
        step(70);
        // R1 enable low stops
        cur_tag = "R1 disable";
        en = 1'b0;
        step(10);
        en = 1'b1;
        cur_tag = "R9 restart";
        step(40);
        @(posedge clk);
        #5;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule